// File: doc/BRIEF.md
# Integer ALU with Compare-and-Set Results

This block is the arithmetic and logic unit of a simple load/store integer core. It takes two 32-bit operands and a 5-bit operation code. From these it produces a 32-bit result and two status flags. Nothing inside it is registered, so the result is valid in the same cycle that the operands and the code arrive. Operand selection takes place before the block, for example choosing between a register and a sign-extended immediate. Writing the result back also takes place outside it.

The supported operations are:
- signed and unsigned add and subtract,
- bitwise AND, OR and XOR,
- three shifts of the first operand by the second,
- pass-through of either operand,
- six signed relations that write 1 or 0 into the result.

The Zero and Negative flags describe whichever result is selected. Multiply, divide and overflow reporting are not part of this block.

Top module: `setcond_alu`

## Requirements
- R1: Codes 0 (signed add) and 1 (unsigned add) both give (A + B) modulo 2^32.
- R2: Codes 2 (signed subtract) and 3 (unsigned subtract) both give (A - B) modulo 2^32.
- R3: Codes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B.
- R4: Code 7 shifts A left by B[4:0] positions and fills with zeros. B[31:5] has no effect on any shift.
- R5: Code 8 shifts A right by B[4:0] positions and fills the vacated upper bits with zeros.
- R6: Code 9 shifts A right by B[4:0] positions and fills the vacated upper bits with copies of A[31].
- R7: Code 10 outputs A unchanged, and code 11 outputs B unchanged.
- R8: Codes 12 (less than), 13 (greater than), 14 (less or equal) and 15 (greater or equal) compare A and B as signed two's-complement values. The result is 1 in bit 0 when the relation holds and 0 otherwise, and bits 31:1 are always zero.
- R9: Codes 16 (equal) and 17 (not equal) give 1 or 0 in bit 0, with bits 31:1 zero.
- R10: Codes 18 to 31 give a result of zero.
- R11: zero_o is 1 exactly when the 32-bit result is all zeros.
- R12: neg_o equals bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; the value that is shifted |
| b_i | input | 32 | Second operand; its bits 4:0 give the shift amount |
| op_i | input | 5 | Operation code |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result bit 31 |

## Verification
The embedded assertions guard properties that follow directly from the operands:
- the signed less-than and equal conditions never hold together,
- compare results never raise the Negative flag,
- a subtract raises Zero exactly when the operands are equal,
- a zero-fill right shift by a nonzero amount clears bit 31,
- a sign-fill right shift of a negative value keeps bit 31 set.

Some behaviour can only be shown by the bench scenarios. These are the exact value of every operation, the fact that the upper shift-amount bits have no effect, the zero result for unused codes, and the signed compare boundaries between the most negative and the most positive values.

// File: rtl/setcond_alu_pkg.sv
package setcond_alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_SLL  = 5'd7,
        OP_SRL  = 5'd8,
        OP_SRA  = 5'd9,
        OP_PA   = 5'd10,
        OP_PB   = 5'd11,
        OP_SLT  = 5'd12,
        OP_SGT  = 5'd13,
        OP_SLE  = 5'd14,
        OP_SGE  = 5'd15,
        OP_SEQ  = 5'd16,
        OP_SNE  = 5'd17
    } alu_op_e;

    function automatic logic is_compare(input logic [OP_W-1:0] op);
        return (op >= OP_SLT) && (op <= OP_SNE);
    endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] diff_o,
    output logic             lt_o,
    output logic             eq_o
);
    localparam int EXT_W = WIDTH + 1;

    typedef struct packed {
        logic [EXT_W-1:0] wide_diff;
        logic [WIDTH-1:0] sum;
        logic             lt;
        logic             eq;
    } arith_t;

    arith_t arith_d;

    always_comb begin
        arith_d           = '0;
        arith_d.sum       = a_i + b_i;
        arith_d.wide_diff = {a_i[WIDTH-1], a_i} - {b_i[WIDTH-1], b_i};
        arith_d.lt        = arith_d.wide_diff[EXT_W-1];
        arith_d.eq        = ~|(a_i ^ b_i);
    end

    assign sum_o  = arith_d.sum;
    assign diff_o = arith_d.wide_diff[WIDTH-1:0];
    assign lt_o   = arith_d.lt;
    assign eq_o   = arith_d.eq;

    always_comb begin
        if (arith_d.eq) begin
            AST_LT_EQ_EXCL: assert (!arith_d.lt); // R8
        end
    end
endmodule

// File: rtl/alu_bitshift.sv
module alu_bitshift #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] sll_o,
    output logic [WIDTH-1:0] srl_o,
    output logic [WIDTH-1:0] sra_o
);
    localparam int SH_W = $clog2(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] land;
        logic [WIDTH-1:0] lor;
        logic [WIDTH-1:0] lxor;
        logic [WIDTH-1:0] sll;
        logic [WIDTH-1:0] srl;
        logic [WIDTH-1:0] sra;
    } bs_t;

    bs_t            bs_d;
    logic [SH_W-1:0] shamt_d;

    always_comb begin
        shamt_d  = b_i[SH_W-1:0];
        bs_d     = '0;
        bs_d.land = a_i & b_i;
        bs_d.lor  = a_i | b_i;
        bs_d.lxor = a_i ^ b_i;
        bs_d.sll  = a_i << shamt_d;
        bs_d.srl  = a_i >> shamt_d;
        bs_d.sra  = $signed(a_i) >>> shamt_d;
    end

    assign and_o = bs_d.land;
    assign or_o  = bs_d.lor;
    assign xor_o = bs_d.lxor;
    assign sll_o = bs_d.sll;
    assign srl_o = bs_d.srl;
    assign sra_o = bs_d.sra;
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             zero_o,
    output logic             neg_o
);
    typedef struct packed {
        logic zero;
        logic neg;
    } flags_t;

    flags_t flags_d;

    always_comb begin
        flags_d.zero = (res_i == '0);
        flags_d.neg  = res_i[WIDTH-1];
    end

    assign zero_o = flags_d.zero;
    assign neg_o  = flags_d.neg;
endmodule

// File: rtl/setcond_alu.sv
module setcond_alu
    import setcond_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             neg_o
);
    localparam int SH_W = $clog2(WIDTH);

    logic [WIDTH-1:0] sum_w, diff_w;
    logic             lt_w, eq_w;
    logic [WIDTH-1:0] and_w, or_w, xor_w, sll_w, srl_w, sra_w;
    logic             zero_w, neg_w;

    typedef struct packed {
        logic             cond;
        logic [WIDTH-1:0] res;
    } sel_t;

    sel_t sel_d;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sum_o (sum_w),
        .diff_o(diff_w),
        .lt_o  (lt_w),
        .eq_o  (eq_w)
    );

    alu_bitshift #(.WIDTH(WIDTH)) u_bitshift (
        .a_i  (a_i),
        .b_i  (b_i),
        .and_o(and_w),
        .or_o (or_w),
        .xor_o(xor_w),
        .sll_o(sll_w),
        .srl_o(srl_w),
        .sra_o(sra_w)
    );

    always_comb begin
        sel_d = '0;
        case (op_i)
            OP_SLT:  sel_d.cond = lt_w;
            OP_SGT:  sel_d.cond = !lt_w && !eq_w;
            OP_SLE:  sel_d.cond = lt_w || eq_w;
            OP_SGE:  sel_d.cond = !lt_w;
            OP_SEQ:  sel_d.cond = eq_w;
            OP_SNE:  sel_d.cond = !eq_w;
            default: sel_d.cond = 1'b0;
        endcase

        case (op_i)
            OP_ADD, OP_ADDU: sel_d.res = sum_w;
            OP_SUB, OP_SUBU: sel_d.res = diff_w;
            OP_AND:          sel_d.res = and_w;
            OP_OR:           sel_d.res = or_w;
            OP_XOR:          sel_d.res = xor_w;
            OP_SLL:          sel_d.res = sll_w;
            OP_SRL:          sel_d.res = srl_w;
            OP_SRA:          sel_d.res = sra_w;
            OP_PA:           sel_d.res = a_i;
            OP_PB:           sel_d.res = b_i;
            OP_SLT, OP_SGT, OP_SLE, OP_SGE, OP_SEQ, OP_SNE:
                             sel_d.res = {{(WIDTH-1){1'b0}}, sel_d.cond};
            default:         sel_d.res = '0;
        endcase
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i (sel_d.res),
        .zero_o(zero_w),
        .neg_o (neg_w)
    );

    assign result_o = sel_d.res;
    assign zero_o   = zero_w;
    assign neg_o    = neg_w;

    always_comb begin
        if (is_compare(op_i)) begin
            AST_CMP_NOT_NEG: assert (!neg_w); // R12
        end
        if (op_i == OP_SUB || op_i == OP_SUBU) begin
            AST_SUB_ZERO_EQ: assert (zero_w == (a_i == b_i)); // R11
        end
        if (op_i == OP_SRL && b_i[SH_W-1:0] != '0) begin
            AST_SRL_TOP_CLEAR: assert (!result_o[WIDTH-1]); // R5
        end
        if (op_i == OP_SRA && a_i[WIDTH-1]) begin
            AST_SRA_SIGN_KEPT: assert (result_o[WIDTH-1]); // R6
        end
    end
endmodule

// File: tb/tb_setcond_alu.sv
`timescale 1ns/1ps
module tb_setcond_alu;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  op = '0;
    logic [31:0] res;
    logic        zf, nf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    setcond_alu dut (
        .a_i(a), .b_i(b), .op_i(op),
        .result_o(res), .zero_o(zf), .neg_o(nf)
    );

    function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        int sh;
        sh = int'(y % 32);
        r = '0;
        case (o)
            5'd0, 5'd1: r = x + y;
            5'd2, 5'd3: r = x + (~y) + 32'd1;
            5'd4: r = x & y;
            5'd5: r = x | y;
            5'd6: r = x ^ y;
            5'd7: for (int i = 0; i < 32; i++) r[i] = (i >= sh) ? x[i-sh] : 1'b0;
            5'd8: for (int i = 0; i < 32; i++) r[i] = (i + sh < 32) ? x[i+sh] : 1'b0;
            5'd9: for (int i = 0; i < 32; i++) r[i] = (i + sh < 32) ? x[i+sh] : x[31];
            5'd10: r = x;
            5'd11: r = y;
            5'd12: r = {31'd0, $signed(x) <  $signed(y)};
            5'd13: r = {31'd0, $signed(x) >  $signed(y)};
            5'd14: r = {31'd0, $signed(x) <= $signed(y)};
            5'd15: r = {31'd0, $signed(x) >= $signed(y)};
            5'd16: r = {31'd0, x == y};
            5'd17: r = {31'd0, x != y};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1: return "R1";
            5'd2, 5'd3: return "R2";
            5'd4, 5'd5, 5'd6: return "R3";
            5'd7: return "R4";
            5'd8: return "R5";
            5'd9: return "R6";
            5'd10, 5'd11: return "R7";
            5'd12, 5'd13, 5'd14, 5'd15: return "R8";
            5'd16, 5'd17: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] e;
        @(posedge clk);
        op = o; a = x; b = y;
        #1;
        e = model(o, x, y);
        check(req_of(o), res, e);
        check("R11", {31'd0, zf}, {31'd0, e == 32'd0});
        check("R12", {31'd0, nf}, {31'd0, e[31]});
    endtask

    initial begin
        int unsigned seed;
        logic [31:0] ra, rb;
        logic [4:0]  ro;
        #1;
        check("R11", {31'd0, zf}, 32'd1);
        check("R1", res, 32'd0);

        apply(5'd0, 32'hFFFF_FFFF, 32'd1);
        apply(5'd1, 32'h7FFF_FFFF, 32'd1);
        apply(5'd2, 32'd0, 32'd1);
        apply(5'd3, 32'h1234_5678, 32'h1234_5678);
        apply(5'd4, 32'hF0F0_F0F0, 32'hFF00_FF00);
        apply(5'd5, 32'hF0F0_F0F0, 32'h0F0F_0000);
        apply(5'd6, 32'hAAAA_AAAA, 32'hFFFF_FFFF);
        apply(5'd7, 32'h8000_0001, 32'hFFFF_FFE3);
        apply(5'd7, 32'h0000_0001, 32'd31);
        apply(5'd8, 32'h8000_0000, 32'hFFFF_FFFF);
        apply(5'd8, 32'hFFFF_FFFF, 32'h0000_0020);
        apply(5'd9, 32'h8000_0000, 32'd31);
        apply(5'd9, 32'h8000_0010, 32'h0000_0104);
        apply(5'd9, 32'h4000_0000, 32'd4);
        apply(5'd10, 32'hDEAD_BEEF, 32'd5);
        apply(5'd11, 32'd5, 32'hCAFE_F00D);
        apply(5'd12, 32'h8000_0000, 32'h7FFF_FFFF);
        apply(5'd13, 32'h8000_0000, 32'h7FFF_FFFF);
        apply(5'd12, 32'hFFFF_FFFF, 32'd0);
        apply(5'd14, 32'd7, 32'd7);
        apply(5'd15, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(5'd13, 32'd7, 32'd7);
        apply(5'd16, 32'hABCD_0000, 32'hABCD_0000);
        apply(5'd17, 32'hABCD_0000, 32'hABCD_0001);
        apply(5'd18, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(5'd31, 32'h8000_0000, 32'h1);

        seed = 32'd12345;
        void'($urandom(seed));
        for (int n = 0; n < 3000; n++) begin
            ro = 5'($urandom_range(0, 31));
            ra = $urandom();
            rb = $urandom();
            if (($urandom() % 4) == 0) rb = ra;
            if (($urandom() % 8) == 0) ra = {ra[31], 31'd0};
            apply(ro, ra, rb);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule